// File: doc/BRIEF.md
# Receive Line Output Formatter

This block sits between a line receiver's clock and data recovery and the two receive data output pins. Each receive clock it samples a pair of recovered rail bits, one marking a positive pulse and one a negative pulse. It then either forwards them unchanged (bipolar mode) or folds them into a single binary stream (NRZ mode). In NRZ mode the second output is reused as an error strobe. The strobe goes high for one clock whenever the received bit breaks the alternate-mark line code, carries an impossible symbol, or ends an over-long run of zeros.

Line-code tracking is a three-state machine that remembers the polarity of the last mark. Its states are `MARK_NONE` (no mark since reset), `MARK_POS` and `MARK_NEG`. A positive-only bit takes the transition *take_pos* into `MARK_POS`. A negative-only bit takes *take_neg* into `MARK_NEG`. A space, or a bit with both rails set, takes *hold* and keeps the current state. A separate run counter counts consecutive spaces. An edge-select input chooses whether the formatted pair is presented on the rising edge of the receive clock, or half a period later on its falling edge, so that a downstream framer can sample on either edge.

Top module: `rx_line_formatter`

## Requirements
- R1: While `rst_n` is low both outputs are low. After reset the machine is in `MARK_NONE` and the space run is zero, so the first mark after reset raises no error, and spaces sent before a reset do not count toward the run afterwards.
- R2: With `nrz_en` = 0, the rails sampled at one rising edge appear on the outputs one clock later: `out_p` = `rail_p` and `out_n` = `rail_n`. No error is ever shown in this mode.
- R3: With `nrz_en` = 1, `out_p` carries the decoded bit, which is `rail_p` OR `rail_n`, with one clock of latency.
- R4: With `nrz_en` = 1, a positive-only bit while in `MARK_POS`, or a negative-only bit while in `MARK_NEG`, drives `out_n` high together with that bit's data. Spaces between the two marks do not clear the remembered polarity.
- R5: With `nrz_en` = 1, a bit with both rails high is a code violation and drives `out_n` high. It leaves the mark state unchanged.
- R6: With `nrz_en` = 1, the 16th consecutive space (ZERO_LIMIT + 1 with the default of 15) drives `out_n` high once. Further spaces raise nothing until a mark restarts the run.
- R7: Each error strobe is exactly one clock wide per offending bit, and `out_n` is low for every bit that carries no error.
- R8: With `fall_sel` = 0 the outputs change on the rising edge that captures the bit. With `fall_sel` = 1 they change on the following falling edge, half a period later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nrz_en | input | 1 | 0 = bipolar pass-through, 1 = merged data plus error strobe |
| fall_sel | input | 1 | 0 = update on rising edge, 1 = update on falling edge |
| rail_p | input | 1 | Recovered positive-pulse rail |
| rail_n | input | 1 | Recovered negative-pulse rail |
| out_p | output | 1 | Positive rail (bipolar) or decoded data (NRZ) |
| out_n | output | 1 | Negative rail (bipolar) or error strobe (NRZ) |

## Verification
A clean alternating-mark sequence shows that data merging raises no false strobes. Repeated same-polarity marks with spaces between them show that the remembered polarity survives spaces, as distinct from a design that only compares adjacent bits. A both-rails symbol followed by a mark shows whether a code violation disturbs the mark state. Runs of 20 and then exactly 16 spaces pin the zero limit and the fire-once rule. The same streams are replayed in bipolar mode and with falling-edge output, and a probe a quarter period after the capturing edge tells the two edge settings apart.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;
    typedef enum logic [1:0] {
        MARK_NONE = 2'd0,
        MARK_POS  = 2'd1,
        MARK_NEG  = 2'd2
    } mark_state_t;

    typedef struct packed {
        logic p;
        logic n;
    } rail_pair_t;
endpackage

// File: rtl/rxfmt_mark_fsm.sv
module rxfmt_mark_fsm
    import rxfmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rail_p,
    input  logic        rail_n,
    output mark_state_t state_q,
    output logic        bpv,
    output logic        cv
);
    mark_state_t state_d;
    logic pos_only;
    logic neg_only;

    assign pos_only = rail_p & ~rail_n;
    assign neg_only = rail_n & ~rail_p;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MARK_NONE;
        else        state_q <= state_d;
    end

    // transitions: take_pos, take_neg, hold
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MARK_NONE, MARK_POS, MARK_NEG: begin
                if (pos_only)      state_d = MARK_POS;
                else if (neg_only) state_d = MARK_NEG;
                else               state_d = state_q;
            end
            default: state_d = MARK_NONE;
        endcase
    end

    // outputs
    always_comb begin
        cv  = rail_p & rail_n;
        bpv = 1'b0;
        unique case (state_q)
            MARK_NONE: bpv = 1'b0;
            MARK_POS:  bpv = pos_only;
            MARK_NEG:  bpv = neg_only;
            default:   bpv = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxfmt_zero_run.sv
module rxfmt_zero_run #(
    parameter int ZERO_LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark,
    output logic exz
);
    localparam int CW = $clog2(ZERO_LIMIT + 2);
    localparam logic [CW-1:0] FIRE_AT = CW'(ZERO_LIMIT);
    localparam logic [CW-1:0] SAT_AT  = CW'(ZERO_LIMIT + 1);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              run_q <= '0;
        else if (mark)           run_q <= '0;
        else if (run_q != SAT_AT) run_q <= run_q + 1'b1;
    end

    assign exz = ~mark & (run_q == FIRE_AT);
endmodule

// File: rtl/rxfmt_edge_stage.sv
module rxfmt_edge_stage
    import rxfmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fall_sel,
    input  rail_pair_t rise_q,
    output rail_pair_t pins
);
    rail_pair_t fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= rise_q;
    end

    assign pins = fall_sel ? fall_q : rise_q;
endmodule

// File: rtl/rx_line_formatter.sv
module rx_line_formatter
    import rxfmt_pkg::*;
#(
    parameter int ZERO_LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_en,
    input  logic fall_sel,
    input  logic rail_p,
    input  logic rail_n,
    output logic out_p,
    output logic out_n
);
    mark_state_t mark_state;
    logic        bpv;
    logic        cv;
    logic        exz;
    rail_pair_t  fmt_d;
    rail_pair_t  fmt_q;
    rail_pair_t  pins;

    rxfmt_mark_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rail_p(rail_p), .rail_n(rail_n),
        .state_q(mark_state), .bpv(bpv), .cv(cv)
    );

    rxfmt_zero_run #(.ZERO_LIMIT(ZERO_LIMIT)) u_run (
        .clk(clk), .rst_n(rst_n), .mark(rail_p | rail_n), .exz(exz)
    );

    always_comb begin
        if (nrz_en) begin
            fmt_d.p = rail_p | rail_n;
            fmt_d.n = bpv | cv | exz;
        end else begin
            fmt_d.p = rail_p;
            fmt_d.n = rail_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fmt_q <= '0;
        else        fmt_q <= fmt_d;
    end

    rxfmt_edge_stage u_edge (
        .clk(clk), .rst_n(rst_n), .fall_sel(fall_sel),
        .rise_q(fmt_q), .pins(pins)
    );

    assign out_p = pins.p;
    assign out_n = pins.n;
endmodule

// File: rtl/rxfmt_checker.sv
module rxfmt_checker
    import rxfmt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        nrz_en,
    input logic        fall_sel,
    input logic        rail_p,
    input logic        rail_n,
    input logic        out_p,
    input logic        out_n,
    input mark_state_t mark_state,
    input logic        exz
);
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    always @(posedge clk) begin
        if (!rst_n) assert_reset_low_R1: assert (!out_p && !out_n);
    end

    assert_bipolar_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(nrz_en) && !fall_sel)
        |-> (out_p == $past(rail_p) && out_n == $past(rail_n)));

    assert_nrz_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(nrz_en) && !fall_sel)
        |-> (out_p == $past(rail_p | rail_n)));

    assert_bpv_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(nrz_en) && !fall_sel &&
         $past((rail_p && !rail_n && mark_state == MARK_POS) ||
               (rail_n && !rail_p && mark_state == MARK_NEG)))
        |-> out_n);

    assert_cv_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(nrz_en) && !fall_sel && $past(rail_p && rail_n))
        |-> out_n);

    assert_cv_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_p && rail_n) |=> (mark_state == $past(mark_state)));

    assert_exz_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(nrz_en) && !fall_sel && $past(exz)) |-> out_n);

    assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(nrz_en) && !fall_sel && out_n)
        |-> $past((rail_p && rail_n) || exz ||
                  (rail_p && !rail_n && mark_state == MARK_POS) ||
                  (rail_n && !rail_p && mark_state == MARK_NEG)));
endmodule

bind rx_line_formatter rxfmt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .nrz_en(nrz_en), .fall_sel(fall_sel),
    .rail_p(rail_p), .rail_n(rail_n), .out_p(out_p), .out_n(out_n),
    .mark_state(mark_state), .exz(exz)
);

// File: tb/sim_rx_line_formatter.sv
module sim_rx_line_formatter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nrz_en = 1'b0;
    logic fall_sel = 1'b0;
    logic rail_p = 1'b0;
    logic rail_n = 1'b0;
    logic out_p;
    logic out_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        int    due;
        bit    p;
        bit    n;
        string tag;
    } exp_t;
    exp_t q[$];

    // bench model of the line code state
    int  m_last = 0;   // 0 none, 1 pos, 2 neg
    int  m_run = 0;
    bit  m_prev_err = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    rx_line_formatter u0 (
        .clk(clk), .rst_n(rst_n), .nrz_en(nrz_en), .fall_sel(fall_sel),
        .rail_p(rail_p), .rail_n(rail_n), .out_p(out_p), .out_n(out_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic send(bit p, bit n);
        exp_t e;
        bit err;
        string tag;
        @(posedge clk);
        #1;
        rail_p = p;
        rail_n = n;
        err = 1'b0;
        tag = "R3";
        if (p && n) begin
            err = 1'b1; tag = "R5";
        end else if (p) begin
            err = (m_last == 1); if (err) tag = "R4";
            m_last = 1; m_run = 0;
        end else if (n) begin
            err = (m_last == 2); if (err) tag = "R4";
            m_last = 2; m_run = 0;
        end else begin
            if (m_run < 17) m_run++;
            err = (m_run == 16); if (err) tag = "R6";
        end
        if (!nrz_en) tag = "R2";
        else if (!err && m_prev_err) tag = "R7";
        if (fall_sel) tag = {tag, "/R8"};
        e.due = cyc + 1;
        e.p = nrz_en ? (p | n) : p;
        e.n = nrz_en ? err : n;
        e.tag = tag;
        m_prev_err = nrz_en && err;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #6;
            if (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, {out_p, out_n}, {e.p, e.n});
            end
        end
    end

    task automatic reset_to(bit nrz, bit sel);
        repeat (2) @(posedge clk);
        #1;
        rail_p = 1'b0;
        rail_n = 1'b0;
        rst_n = 1'b0;
        nrz_en = nrz;
        fall_sel = sel;
        m_last = 0;
        m_run = 0;
        m_prev_err = 1'b0;
        @(posedge clk);
        #2;
        chk("R1", {out_p, out_n}, 2'b00);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic code_stream();
        send(1,0); send(0,0); send(1,0); send(0,1); send(0,1);
        send(1,1); send(0,1); send(1,0); send(0,0); send(0,0);
        send(0,1); send(1,0);
    endtask

    task automatic spaces(int k);
        for (int i = 0; i < k; i++) send(0,0);
    endtask

    task automatic edge_probe(bit sel);
        reset_to(1'b0, sel);
        send(0,0);
        send(1,0);
        @(posedge clk);
        #2;
        chk("R8", {out_p, out_n}, sel ? 2'b00 : 2'b10);
        reset_to(1'b0, 1'b0);
    endtask

    initial begin
        reset_to(1'b0, 1'b0);
        // bipolar pass-through, rising edge
        code_stream();
        // NRZ merge with violations, rising edge
        reset_to(1'b1, 1'b0);
        code_stream();
        // zero runs: 20 spaces, mark, exactly 16 spaces, mark
        spaces(20); send(1,0); spaces(16); send(0,1);
        // space count cleared by reset
        spaces(10);
        reset_to(1'b1, 1'b0);
        spaces(10); send(1,0);
        // falling-edge presentation in both modes
        reset_to(1'b1, 1'b1);
        code_stream();
        spaces(17);
        reset_to(1'b0, 1'b1);
        code_stream();
        // edge-select timing probes
        edge_probe(1'b0);
        edge_probe(1'b1);
        repeat (3) @(posedge clk);
        if (q.size() != 0) chk("R7", 2'(q.size()), 2'b00);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule